// File: doc/BRIEF.md
# Indexed Effective-Address Unit

This block turns the addressing byte of an indexed-mode instruction into a 16-bit effective address. A caller pulses `start` with the addressing byte, up to two offset bytes taken from the instruction stream, the four index registers, both accumulators and the program counter. The byte names one of four base registers and one of many addressing forms: a short signed 5-bit displacement, automatic increment or decrement by one or two, accumulator offsets, 8- and 16-bit constant offsets, program-counter-relative offsets and an absolute pointer. Any form, apart from a few excluded ones, can add a level of indirection.

For the increment and decrement forms the unit reports the new value of the base register so the caller can write it back. When indirection is requested, the unit reads a big-endian word through a byte-wide memory port and returns that word as the final address. Each completion also reports the number of extra internal cycles the form takes. Byte codes that do not name a valid form are flagged as illegal, and the base register is returned in their place.

Top module: `idx_ea_unit`

## Requirements
- R1: Bits 6:5 of the addressing byte select the base register: 00 X, 01 Y, 10 U, 11 S. `wb_sel` carries the same code.
- R2: With bit 7 clear, the address is the base plus bits 4:0 read as a signed value. `done` pulses one cycle after `start`, and `extra_cycles` is 1.
- R3: With bit 7 set, low nibble 0000 returns the base and writes back base+1. Nibble 0001 returns the base and writes back base+2. `wb_en` pulses only together with `done`.
- R4: Low nibble 0010 returns base−1 and nibble 0011 returns base−2. In both cases the returned value is also written back.
- R5: Low nibble 0100 returns the base unchanged. 0101 adds signed B, 0110 adds signed A and 1000 adds signed `ofs_lo`. 1001 adds {`ofs_hi`,`ofs_lo`} and 1011 adds {A,B}, all modulo 2^16.
- R6: `pc_next` is the address just after the addressing byte. Nibble 1100 gives `pc_next`+1+signed `ofs_lo`, and nibble 1101 gives `pc_next`+2+{`ofs_hi`,`ofs_lo`}. The base-register bits have no effect.
- R7: With bits 7 and 4 both set, the computed address is a pointer. Two reads are issued: first at the pointer, then at pointer+1. Read data arrives on the cycle after `mem_rd`. The final address is {first byte, second byte}, and `done` follows 4 cycles after `start`.
- R8: Nibble 1111 with bit 4 set uses {`ofs_hi`,`ofs_lo`} as the pointer.
- R9: The following codes are illegal: nibbles 0111, 1010 and 1110; nibbles 0000 and 0010 with bit 4 set; nibble 1111 with bit 4 clear. An illegal code raises `illegal` and returns the base. It makes no read and no write-back, reports 0 extra cycles, and completes after one cycle.
- R10: `extra_cycles` takes these values: 5-bit form 1; 0000 2; 0001 3; 0010 2; 0011 3; 0100 0; 0101, 0110 and 1000 1; 1001 3; 1011 4; 1100 1; 1101 4; 1111 1. Indirection adds 1.
- R11: A `start` that arrives while `busy` is high is ignored.
- R12: After reset, `done`, `busy`, `mem_rd`, `illegal` and `wb_en` are low, and `ea` and `extra_cycles` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address computation |
| postbyte | input | 8 | Indexed addressing byte |
| ofs_hi | input | 8 | First extra instruction byte |
| ofs_lo | input | 8 | Second (or only) extra instruction byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_u | input | 16 | User stack pointer |
| reg_s | input | 16 | System stack pointer |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_next | input | 16 | Address following the addressing byte |
| mem_rd | output | 1 | Memory byte read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Indirect read in progress |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| illegal | output | 1 | Invalid addressing byte |
| extra_cycles | output | 4 | Internal cycle cost of the form |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 2 | Register to write back |
| wb_value | output | 16 | Value to write back |

## Verification
The hardest case to reach is a `start` arriving while an indirect read is still in progress, especially when that second request names a form that would write back. To create it, the bench launches an indirect request, waits until `busy` is high, and then pulses `start` with a post-increment byte. It then checks three things: exactly one completion occurs, that completion carries the indirect word, and no write-back strobe is seen. The ordering of the two reads in the indirect path is checked by giving the two memory bytes different values, so that swapping them produces a different address.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CYC_W  = 4;

    typedef enum logic [3:0] {
        M_INC1  = 4'b0000,
        M_INC2  = 4'b0001,
        M_DEC1  = 4'b0010,
        M_DEC2  = 4'b0011,
        M_ZERO  = 4'b0100,
        M_ACCB  = 4'b0101,
        M_ACCA  = 4'b0110,
        M_RSV7  = 4'b0111,
        M_OFF8  = 4'b1000,
        M_OFF16 = 4'b1001,
        M_RSVA  = 4'b1010,
        M_ACCD  = 4'b1011,
        M_PC8   = 4'b1100,
        M_PC16  = 4'b1101,
        M_RSVE  = 4'b1110,
        M_EXT   = 4'b1111
    } idx_mode_e;

    typedef struct packed {
        logic              is_short;
        logic [4:0]        off5;
        idx_mode_e         mode;
        logic              indirect;
        logic [1:0]        base_sel;
        logic              illegal;
        logic [CYC_W-1:0]  cycles;
    } idx_dec_t;

    function automatic logic [ADDR_W-1:0] sext5(input logic [4:0] v);
        return {{(ADDR_W-5){v[4]}}, v};
    endfunction

    function automatic logic [ADDR_W-1:0] sext8(input logic [BYTE_W-1:0] v);
        return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
    endfunction

    function automatic logic [CYC_W-1:0] mode_cost(input logic is_short,
                                                   input idx_mode_e m,
                                                   input logic ind);
        logic [CYC_W-1:0] c;
        if (is_short) begin
            c = CYC_W'(1);
        end else begin
            unique case (m)
                M_INC1, M_DEC1:           c = CYC_W'(2);
                M_INC2, M_DEC2, M_OFF16:  c = CYC_W'(3);
                M_ACCD, M_PC16:           c = CYC_W'(4);
                M_ZERO:                   c = CYC_W'(0);
                default:                  c = CYC_W'(1);
            endcase
            if (ind) c = c + CYC_W'(1);
        end
        return c;
    endfunction

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
    import idx_ea_pkg::*;
(
    input  logic [BYTE_W-1:0] postbyte,
    output idx_dec_t          dec
);
    logic bad_code;

    always_comb begin
        dec.is_short = ~postbyte[7];
        dec.off5     = postbyte[4:0];
        dec.mode     = idx_mode_e'(postbyte[3:0]);
        dec.indirect = postbyte[7] & postbyte[4];
        dec.base_sel = postbyte[6:5];

        bad_code = (dec.mode == M_RSV7) || (dec.mode == M_RSVA) ||
                   (dec.mode == M_RSVE) ||
                   (dec.indirect && (dec.mode == M_INC1 || dec.mode == M_DEC1)) ||
                   (!dec.indirect && dec.mode == M_EXT);
        dec.illegal = postbyte[7] & bad_code;
        dec.cycles  = dec.illegal ? '0
                                  : mode_cost(dec.is_short, dec.mode, dec.indirect);
    end
endmodule

// File: rtl/idx_ea_adder.sv
module idx_ea_adder
    import idx_ea_pkg::*;
(
    input  logic              is_short,
    input  logic [4:0]        off5,
    input  idx_mode_e         mode,
    input  logic [1:0]        base_sel,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_u,
    input  logic [ADDR_W-1:0] reg_s,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    input  logic [BYTE_W-1:0] ofs_hi,
    input  logic [BYTE_W-1:0] ofs_lo,
    input  logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_val
);
    logic [ADDR_W-1:0] word_ofs;

    always_comb begin
        unique case (base_sel)
            2'b00:   base = reg_x;
            2'b01:   base = reg_y;
            2'b10:   base = reg_u;
            default: base = reg_s;
        endcase
    end

    assign word_ofs = {ofs_hi, ofs_lo};

    always_comb begin
        addr   = base;
        wb_req = 1'b0;
        wb_val = base;
        if (is_short) begin
            addr = base + sext5(off5);
        end else begin
            unique case (mode)
                M_INC1:  begin wb_req = 1'b1; wb_val = base + ADDR_W'(1); end
                M_INC2:  begin wb_req = 1'b1; wb_val = base + ADDR_W'(2); end
                M_DEC1:  begin addr = base - ADDR_W'(1); wb_req = 1'b1; wb_val = addr; end
                M_DEC2:  begin addr = base - ADDR_W'(2); wb_req = 1'b1; wb_val = addr; end
                M_ACCB:  addr = base + sext8(acc_b);
                M_ACCA:  addr = base + sext8(acc_a);
                M_OFF8:  addr = base + sext8(ofs_lo);
                M_OFF16: addr = base + word_ofs;
                M_ACCD:  addr = base + {acc_a, acc_b};
                M_PC8:   addr = pc_next + ADDR_W'(1) + sext8(ofs_lo);
                M_PC16:  addr = pc_next + ADDR_W'(2) + word_ofs;
                M_EXT:   addr = word_ofs;
                default: addr = base;
            endcase
        end
    end
endmodule

// File: rtl/idx_ea_indirect.sv
module idx_ea_indirect
    import idx_ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] ptr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              word_ok,
    output logic [ADDR_W-1:0] word
);
    typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_TAIL} ind_state_e;

    ind_state_e        state;
    logic [ADDR_W-1:0] ptr_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ptr_q <= '0;
            hi_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (go) begin
                    ptr_q <= ptr;
                    state <= S_HI;
                end
                S_HI:   state <= S_LO;
                S_LO:   begin
                    hi_q  <= mem_rdata;
                    state <= S_TAIL;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_rd   = (state == S_HI) || (state == S_LO);
    assign mem_addr = (state == S_LO) ? ptr_q + ADDR_W'(1) : ptr_q;
    assign busy     = (state != S_IDLE);
    assign word_ok  = (state == S_TAIL);
    assign word     = {hi_q, mem_rdata};
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
    import idx_ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  postbyte,
    input  logic [7:0]  ofs_hi,
    input  logic [7:0]  ofs_lo,
    input  logic [15:0] reg_x,
    input  logic [15:0] reg_y,
    input  logic [15:0] reg_u,
    input  logic [15:0] reg_s,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    input  logic [15:0] pc_next,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] ea,
    output logic        illegal,
    output logic [3:0]  extra_cycles,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_value
);
    idx_dec_t          dec;
    logic [ADDR_W-1:0] base, addr, wb_val_c, word;
    logic              wb_req, word_ok, accept, go_ind;

    idx_ea_decode u_dec (.postbyte(postbyte), .dec(dec));

    idx_ea_adder u_add (
        .is_short(dec.is_short), .off5(dec.off5), .mode(dec.mode),
        .base_sel(dec.base_sel),
        .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s),
        .acc_a(acc_a), .acc_b(acc_b), .ofs_hi(ofs_hi), .ofs_lo(ofs_lo),
        .pc_next(pc_next), .base(base), .addr(addr),
        .wb_req(wb_req), .wb_val(wb_val_c)
    );

    assign accept = start && !busy;
    assign go_ind = accept && dec.indirect && !dec.illegal;

    idx_ea_indirect u_ind (
        .clk(clk), .rst(rst), .go(go_ind), .ptr(addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .word_ok(word_ok), .word(word)
    );

    logic              done_q, illegal_q, wb_q, wb_pend_q;
    logic [ADDR_W-1:0] ea_q, wbv_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [1:0]        wbsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            wb_q      <= 1'b0;
            wb_pend_q <= 1'b0;
            ea_q      <= '0;
            wbv_q     <= '0;
            cyc_q     <= '0;
            wbsel_q   <= '0;
        end else begin
            done_q <= 1'b0;
            wb_q   <= 1'b0;
            if (accept) begin
                cyc_q     <= dec.cycles;
                wbsel_q   <= dec.base_sel;
                wbv_q     <= wb_val_c;
                illegal_q <= dec.illegal;
                if (go_ind) begin
                    wb_pend_q <= wb_req;
                end else begin
                    done_q <= 1'b1;
                    ea_q   <= dec.illegal ? base : addr;
                    wb_q   <= wb_req && !dec.illegal;
                end
            end
            if (word_ok) begin
                done_q    <= 1'b1;
                ea_q      <= word;
                wb_q      <= wb_pend_q;
                wb_pend_q <= 1'b0;
            end
        end
    end

    assign done         = done_q;
    assign ea           = ea_q;
    assign illegal      = illegal_q;
    assign extra_cycles = cyc_q;
    assign wb_en        = wb_q;
    assign wb_sel       = wbsel_q;
    assign wb_value     = wbv_q;
endmodule

// File: rtl/idx_ea_checker.sv
module idx_ea_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [7:0]  postbyte,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic [3:0]  extra_cycles,
    input logic        wb_en,
    input logic        mem_rd,
    input logic [15:0] mem_addr
);
    // R2: the short-displacement form completes on the next cycle
    assert_short_form_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !postbyte[7]) |=> (done && !illegal && extra_cycles == 4'd1));

    // R9: an illegal completion neither writes back nor costs cycles
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> (!wb_en && extra_cycles == 4'd0));

    // R7: the second pointer read follows at the next byte address
    assert_read_pair_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd) |=> (mem_rd && mem_addr == $past(mem_addr) + 16'd1));

    // R11: memory reads only occur inside a busy window
    assert_read_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    // R3: write-back strobe only accompanies a completion
    assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);
endmodule

bind idx_ea_unit idx_ea_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .postbyte(postbyte), .busy(busy),
    .done(done), .illegal(illegal), .extra_cycles(extra_cycles),
    .wb_en(wb_en), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/tb_idx_ea_unit.sv
module tb_idx_ea_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0, ofs_hi = '0, ofs_lo = '0;
    logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_u = 16'h3000, reg_s = 16'h4000;
    logic [7:0]  acc_a = 8'h85, acc_b = 8'h12;
    logic [15:0] pc_next = 16'h8000;
    logic        mem_rd, busy, done, illegal, wb_en;
    logic [15:0] mem_addr, ea, wb_value;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  extra_cycles;
    logic [1:0]  wb_sel;

    int checks = 0, errors = 0;
    int reads = 0, dones = 0, wbs = 0;
    int lat;

    always #10 clk = ~clk;

    idx_ea_unit dut (.*);

    // memory model: byte at address a is the inverse of its low byte
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= ~mem_addr[7:0];
        if (!rst && mem_rd) reads <= reads + 1;
        if (!rst && done)   dones <= dones + 1;
        if (!rst && wb_en)  wbs   <= wbs + 1;
    end

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] pb, input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        postbyte = pb; ofs_hi = hi; ofs_lo = lo; start = 1'b1;
        reads = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset;
        chk("R12 done", done, 0);   chk("R12 busy", busy, 0);
        chk("R12 mem_rd", mem_rd, 0); chk("R12 illegal", illegal, 0);
        chk("R12 wb_en", wb_en, 0); chk("R12 ea", ea, 0);
        chk("R12 cycles", extra_cycles, 0);
    endtask

    task automatic t_short;
        run(8'h1F, 8'h00, 8'h00);
        chk("R2 X-1", ea, 16'h0FFF); chk("R2 latency", lat, 1);
        chk("R2 cycles", extra_cycles, 1); chk("R2 no wb", wb_en, 0);
        run(8'h2F, 8'h00, 8'h00); chk("R1 Y+15", ea, 16'h200F);
        run(8'h50, 8'h00, 8'h00); chk("R1 U-16", ea, 16'h2FF0);
        run(8'h61, 8'h00, 8'h00); chk("R1 S+1", ea, 16'h4001);
    endtask

    task automatic t_autoinc;
        run(8'h80, 8'h00, 8'h00);
        chk("R3 ea", ea, 16'h1000); chk("R3 wb_en", wb_en, 1);
        chk("R3 wb_sel", wb_sel, 0); chk("R3 wb +1", wb_value, 16'h1001);
        chk("R10 R+", extra_cycles, 2);
        run(8'hA1, 8'h00, 8'h00);
        chk("R3 ea Y", ea, 16'h2000); chk("R1 wb_sel Y", wb_sel, 1);
        chk("R3 wb +2", wb_value, 16'h2002); chk("R10 R++", extra_cycles, 3);
    endtask

    task automatic t_predec;
        run(8'hC2, 8'h00, 8'h00);
        chk("R4 ea -1", ea, 16'h2FFF); chk("R4 wb -1", wb_value, 16'h2FFF);
        chk("R4 wb_en", wb_en, 1); chk("R10 -R", extra_cycles, 2);
        run(8'hE3, 8'h00, 8'h00);
        chk("R4 ea -2", ea, 16'h3FFE); chk("R1 wb_sel S", wb_sel, 3);
        chk("R10 --R", extra_cycles, 3);
    endtask

    task automatic t_offsets;
        run(8'h84, 8'h00, 8'h00); chk("R5 none", ea, 16'h1000); chk("R10 ,R", extra_cycles, 0);
        run(8'h85, 8'h00, 8'h00); chk("R5 B", ea, 16'h1012);
        run(8'h86, 8'h00, 8'h00); chk("R5 A neg", ea, 16'h0F85);
        run(8'h88, 8'h00, 8'hF0); chk("R5 n8", ea, 16'h0FF0);
        run(8'h89, 8'h12, 8'h34); chk("R5 n16", ea, 16'h2234); chk("R10 n16", extra_cycles, 3);
        run(8'h8B, 8'h00, 8'h00); chk("R5 D", ea, 16'h9512); chk("R10 D", extra_cycles, 4);
        chk("R5 no reads", reads, 0);
    endtask

    task automatic t_pcrel;
        run(8'h8C, 8'h00, 8'h10); chk("R6 pc8 pos", ea, 16'h8011);
        run(8'hEC, 8'h00, 8'h80); chk("R6 pc8 neg", ea, 16'h7F81);
        run(8'h8D, 8'hFF, 8'h00); chk("R6 pc16", ea, 16'h7F02);
        chk("R10 pc16", extra_cycles, 4);
    endtask

    task automatic t_indirect;
        run(8'h94, 8'h00, 8'h00);
        chk("R7 word", ea, 16'hFFFE); chk("R7 latency", lat, 4);
        chk("R7 reads", reads, 2); chk("R10 [,R]", extra_cycles, 1);
        run(8'h91, 8'h00, 8'h00);
        chk("R7 [R++] word", ea, 16'hFFFE); chk("R3 ind wb", wb_en, 1);
        chk("R3 ind wb value", wb_value, 16'h1002); chk("R10 [R++]", extra_cycles, 4);
        run(8'h9F, 8'h12, 8'h34);
        chk("R8 ext", ea, 16'hCBCA); chk("R10 [n]", extra_cycles, 2);
    endtask

    task automatic t_illegal;
        logic [7:0] codes [4] = '{8'h87, 8'h90, 8'h8F, 8'hAA};
        logic [15:0] bases [4] = '{16'h1000, 16'h1000, 16'h1000, 16'h2000};
        for (int i = 0; i < 4; i++) begin
            run(codes[i], 8'h12, 8'h34);
            chk("R9 flag", illegal, 1); chk("R9 ea base", ea, bases[i]);
            chk("R9 latency", lat, 1);  chk("R9 no wb", wb_en, 0);
            chk("R9 no reads", reads, 0); chk("R9 cycles", extra_cycles, 0);
        end
        run(8'h84, 8'h00, 8'h00); chk("R9 flag clears", illegal, 0);
    endtask

    task automatic t_busy;
        int d0, w0;
        @(negedge clk);
        d0 = dones; w0 = wbs;
        postbyte = 8'h94; start = 1'b1;
        @(negedge clk);
        postbyte = 8'h80;
        chk("R11 busy", busy, 1);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 one done", dones - d0, 1);
        chk("R11 no wb", wbs - w0, 0);
        chk("R11 ea", ea, 16'hFFFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_short;
        t_autoinc;
        t_predec;
        t_offsets;
        t_pcrel;
        t_indirect;
        t_illegal;
        t_busy;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule